// File: doc/BRIEF.md
# Data Address Translation and Protection Unit

This block turns a 32-bit virtual data address into a physical address for a processor load/store pipe, or reports why it cannot. It holds a fully associative translation table of 64 entries. Each entry carries a page number, an address-space tag, a physical page number, a page-size code, two protection bits, a dirty bit and a shared flag. Some fixed address windows skip the table. Every other request is compared against all entries at once. The unit then applies the privilege, write-protect and first-write checks in a fixed order of priority. The result, a physical address and a 3-bit error code, appears one clock after the request.

The table is loaded through a simple write port: an index plus the entry fields. A write takes effect for lookups from the next clock on. A six-bit replacement pointer advances on every request and returns to zero at a programmable bound, so that software can choose a victim slot. A successful translation that lands in the physical window with bits 28..26 all set is moved into the top control-register area.

Top module: `dtlb_xlate`

## Requirements
- R1: `rsp_valid` is high exactly one cycle after each cycle in which `req_valid` is high. `rsp_err` then uses the codes 0 = ok, 1 = miss, 2 = multiple match, 3 = protection violation, 4 = first write to a clean page, 5 = address error. On any nonzero code, `rsp_pa` is zero.
- R2: Alignment is checked before any other rule. For `req_size` 1 (2 bytes), bit 0 must be clear. For `req_size` 2 or 3 (4 and 8 bytes), bits 1..0 must be clear. A violation gives code 5. `req_size` 0 (1 byte) is never misaligned.
- R3: In user mode (`req_user`=1), an address with bit 31 set gives code 5, with one exception. A write to 0xE0000000–0xE3FFFFFF (bits 31..26 = 111000) bypasses the table in either mode and returns the address unchanged.
- R4: An address in 0x7C000000–0x7FFFFFFF (bits 31..26 = 011111) is returned unchanged with code 0, in either mode.
- R5: In privileged mode, addresses whose bits 31..29 equal 4, 5 or 7 are returned unchanged with code 0. Bits 31..29 = 6 go through the table.
- R6: An entry matches when it is valid and the virtual page bits above the page size are equal. Its address-space tag must also equal `cur_asid`, unless the entry is shared or the request is privileged with `single_space` set.
- R7: Two or more matching entries give code 2. No matching entry gives code 1. Both take precedence over the protection checks.
- R8: The page-size code selects 1 KB (0), 4 KB (1), 64 KB (2) or 1 MB (3). The physical address takes the entry's page number (physical bits 28..10) above the page offset and the virtual bits within it.
- R9: A matching entry whose protection bit 1 is clear gives code 3 for a user-mode access.
- R10: On a write, protection bit 0 clear gives code 3. Otherwise, a clear dirty bit gives code 4. Reads ignore both bits.
- R11: A table translation with code 0 whose result has bits 28..26 all set has bits 31..28 forced to ones.
- R12: `repl_idx` resets to 0 and advances by one, modulo 64, on each request. When the advanced value equals `repl_bound`, it becomes 0 instead. Without a request it holds.
- R13: Reset invalidates every entry. A load takes effect for lookups from the following cycle; a lookup in the same cycle as a load sees the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| cur_asid | input | 8 | Current address-space tag |
| single_space | input | 1 | Privileged accesses ignore the address-space tag |
| repl_bound | input | 6 | Wrap bound of the replacement pointer |
| ld_en | input | 1 | Write one table entry |
| ld_idx | input | 6 | Entry index to write |
| ld_vpn | input | 22 | Virtual page number (address bits 31..10) |
| ld_asid | input | 8 | Entry address-space tag |
| ld_ppn | input | 19 | Physical page number (address bits 28..10) |
| ld_valid | input | 1 | Entry valid |
| ld_size | input | 2 | Page-size code |
| ld_prot | input | 2 | Bit 1: user access allowed; bit 0: write allowed |
| ld_dirty | input | 1 | Page already written |
| ld_shared | input | 1 | Match regardless of address-space tag |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 32 | Physical address (zero on error) |
| rsp_err | output | 3 | Error code |
| repl_idx | output | 6 | Replacement pointer |

## Verification
An entry load and a lookup can fall in the same cycle, and the lookup must then see the table as it was before the load. The bench drives both on one clock edge: it loads a slot with a page that the lookup address hits. It expects a miss for that lookup and a hit for an identical lookup one request later. In the random phase, loads and lookups are mixed freely. The replacement pointer also moves on the same edge as every lookup, and the bench checks it after each request against its own count.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int VA_W   = 32;
    localparam int OFS_W  = 10;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PPN_W  = 19;
    localparam int ASID_W = 8;

    typedef enum logic [2:0] {
        XE_NONE    = 3'd0,
        XE_MISS    = 3'd1,
        XE_MULTI   = 3'd2,
        XE_PROT    = 3'd3,
        XE_FIRSTWR = 3'd4,
        XE_ADDR    = 3'd5
    } xlate_err_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic              dirty;
        logic              shared;
    } tlb_ent_t;

    // Page-number bits that take part in the compare for a page size.
    function automatic logic [VPN_W-1:0] vpn_cmp_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        m = '1;
        case (sz)
            2'd1:    m[1:0] = '0;
            2'd2:    m[5:0] = '0;
            2'd3:    m[9:0] = '0;
            default: m = '1;
        endcase
        return m;
    endfunction

    // Address bits that pass through unchanged (page offset).
    function automatic logic [VA_W-1:0] page_ofs_mask(input logic [1:0] sz);
        case (sz)
            2'd1:    return 32'h0000_0FFF;
            2'd2:    return 32'h0000_FFFF;
            2'd3:    return 32'h000F_FFFF;
            default: return 32'h0000_03FF;
        endcase
    endfunction

    function automatic logic misaligned(input logic [VA_W-1:0] va, input logic [1:0] sz);
        case (sz)
            2'd0:    return 1'b0;
            2'd1:    return va[0];
            default: return |va[1:0];
        endcase
    endfunction

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store
    import dtlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  tlb_ent_t          ld_ent,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_asid_ignore,
    output logic              hit_any,
    output logic              hit_multi,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [1:0]        hit_size,
    output logic [1:0]        hit_prot,
    output logic              hit_dirty
);

    tlb_ent_t          ents [N_ENT];
    logic [N_ENT-1:0]  hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) begin
                ents[i] <= '0;
            end
        end else if (ld_en) begin
            ents[ld_idx] <= ld_ent;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic page_eq;
        logic tag_ok;
        assign page_eq = ((ents[g].vpn ^ lk_vpn) & vpn_cmp_mask(ents[g].size)) == '0;
        assign tag_ok  = ents[g].shared || lk_asid_ignore || (ents[g].asid == lk_asid);
        assign hit_vec[g] = ents[g].valid && page_eq && tag_ok;
    end

    always_comb begin
        hit_any   = 1'b0;
        hit_multi = 1'b0;
        hit_ppn   = '0;
        hit_size  = '0;
        hit_prot  = '0;
        hit_dirty = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) begin
                if (hit_any) begin
                    hit_multi = 1'b1;
                end
                hit_any   = 1'b1;
                hit_ppn   = ents[i].ppn;
                hit_size  = ents[i].size;
                hit_prot  = ents[i].prot;
                hit_dirty = ents[i].dirty;
            end
        end
    end

endmodule

// File: rtl/dtlb_repl.sv
module dtlb_repl #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [IDX_W-1:0] bound,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] idx_inc;

    assign idx_inc = idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx_inc == bound) ? '0 : idx_inc;
        end
    end

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(idx));

    assert_advance_or_wrap_R12: assert property (@(posedge clk) disable iff (rst)
        step |=> (idx == '0) || (idx == $past(idx) + 1'b1));

endmodule

// File: rtl/dtlb_resolve.sv
module dtlb_resolve
    import dtlb_pkg::*;
(
    input  logic [VA_W-1:0]  va,
    input  logic             is_write,
    input  logic             is_user,
    input  logic [1:0]       acc_size,
    input  logic             hit_any,
    input  logic             hit_multi,
    input  logic [PPN_W-1:0] hit_ppn,
    input  logic [1:0]       hit_size,
    input  logic [1:0]       hit_prot,
    input  logic             hit_dirty,
    output logic [VA_W-1:0]  pa,
    output xlate_err_e       err
);

    logic            sq_write;
    logic            onchip_win;
    logic            priv_seg;
    logic [VA_W-1:0] ofs_m;
    logic [VA_W-1:0] frame;
    logic [VA_W-1:0] joined;

    assign sq_write   = is_write && (va[31:26] == 6'b111000);
    assign onchip_win = (va[31:26] == 6'b011111);
    assign priv_seg   = !is_user && (va[31:29] == 3'd4 || va[31:29] == 3'd5 || va[31:29] == 3'd7);
    assign ofs_m      = page_ofs_mask(hit_size);
    assign frame      = {3'b000, hit_ppn, {OFS_W{1'b0}}};
    assign joined     = (frame & ~ofs_m) | (va & ofs_m);

    always_comb begin
        pa  = '0;
        err = XE_NONE;
        if (misaligned(va, acc_size)) begin
            err = XE_ADDR;
        end else if (is_user && va[31] && !sq_write) begin
            err = XE_ADDR;
        end else if (onchip_win || sq_write || priv_seg) begin
            pa = va;
        end else if (hit_multi) begin
            err = XE_MULTI;
        end else if (!hit_any) begin
            err = XE_MISS;
        end else if (is_user && !hit_prot[1]) begin
            err = XE_PROT;
        end else if (is_write && !hit_prot[0]) begin
            err = XE_PROT;
        end else if (is_write && !hit_dirty) begin
            err = XE_FIRSTWR;
        end else begin
            pa = joined;
            if (joined[28:26] == 3'b111) begin
                pa[31:28] = 4'hF;
            end
        end
    end

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [1:0]        req_size,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              single_space,
    input  logic [IDX_W-1:0]  repl_bound,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [ASID_W-1:0] ld_asid,
    input  logic [PPN_W-1:0]  ld_ppn,
    input  logic              ld_valid,
    input  logic [1:0]        ld_size,
    input  logic [1:0]        ld_prot,
    input  logic              ld_dirty,
    input  logic              ld_shared,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_pa,
    output logic [2:0]        rsp_err,
    output logic [IDX_W-1:0]  repl_idx
);

    tlb_ent_t         ld_ent;
    logic             hit_any;
    logic             hit_multi;
    logic [PPN_W-1:0] hit_ppn;
    logic [1:0]       hit_size;
    logic [1:0]       hit_prot;
    logic             hit_dirty;
    logic [VA_W-1:0]  rs_pa;
    xlate_err_e       rs_err;

    always_comb begin
        ld_ent.valid  = ld_valid;
        ld_ent.vpn    = ld_vpn;
        ld_ent.asid   = ld_asid;
        ld_ent.ppn    = ld_ppn;
        ld_ent.size   = ld_size;
        ld_ent.prot   = ld_prot;
        ld_ent.dirty  = ld_dirty;
        ld_ent.shared = ld_shared;
    end

    dtlb_store #(.N_ENT(N_ENT)) u_store (
        .clk            (clk),
        .rst            (rst),
        .ld_en          (ld_en),
        .ld_idx         (ld_idx),
        .ld_ent         (ld_ent),
        .lk_vpn         (req_va[VA_W-1:OFS_W]),
        .lk_asid        (cur_asid),
        .lk_asid_ignore (single_space && !req_user),
        .hit_any        (hit_any),
        .hit_multi      (hit_multi),
        .hit_ppn        (hit_ppn),
        .hit_size       (hit_size),
        .hit_prot       (hit_prot),
        .hit_dirty      (hit_dirty)
    );

    dtlb_resolve u_resolve (
        .va        (req_va),
        .is_write  (req_write),
        .is_user   (req_user),
        .acc_size  (req_size),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .hit_ppn   (hit_ppn),
        .hit_size  (hit_size),
        .hit_prot  (hit_prot),
        .hit_dirty (hit_dirty),
        .pa        (rs_pa),
        .err       (rs_err)
    );

    dtlb_repl #(.IDX_W(IDX_W)) u_repl (
        .clk   (clk),
        .rst   (rst),
        .step  (req_valid),
        .bound (repl_bound),
        .idx   (repl_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_err   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa  <= rs_pa;
                rsp_err <= rs_err;
            end
        end
    end

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_err_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_err <= 3'd5);

    assert_miss_means_no_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rs_err == XE_MISS) |-> !hit_any);

    assert_multi_means_multi_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rs_err == XE_MULTI) |-> hit_multi);

    assert_firstwr_only_write_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err == 3'd4) |-> $past(req_write));

    assert_onchip_passthru_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_va[31:26] == 6'b011111 && !misaligned(req_va, req_size)))
        |-> (rsp_err == 3'd0 && rsp_pa == $past(req_va)));

endmodule

// File: tb/dtlb_xlate_bench.sv
module dtlb_xlate_bench;
    import dtlb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_user, single_space;
    logic [31:0] req_va;
    logic [1:0]  req_size;
    logic [7:0]  cur_asid;
    logic [5:0]  repl_bound;
    logic        ld_en, ld_valid, ld_dirty, ld_shared;
    logic [5:0]  ld_idx;
    logic [21:0] ld_vpn;
    logic [7:0]  ld_asid;
    logic [18:0] ld_ppn;
    logic [1:0]  ld_size, ld_prot;
    logic        rsp_valid;
    logic [31:0] rsp_pa;
    logic [2:0]  rsp_err;
    logic [5:0]  repl_idx;

    tlb_ent_t m_ent [NE];
    int exp_urc;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtlb_xlate u_dtlb_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_user(req_user), .req_size(req_size),
        .cur_asid(cur_asid), .single_space(single_space), .repl_bound(repl_bound),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_vpn(ld_vpn), .ld_asid(ld_asid),
        .ld_ppn(ld_ppn), .ld_valid(ld_valid), .ld_size(ld_size), .ld_prot(ld_prot),
        .ld_dirty(ld_dirty), .ld_shared(ld_shared), .rsp_valid(rsp_valid),
        .rsp_pa(rsp_pa), .rsp_err(rsp_err), .repl_idx(repl_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic string tag_of(input logic [2:0] e);
        case (e)
            3'd0: return "R8";
            3'd1, 3'd2: return "R7";
            3'd3: return "R9";
            3'd4: return "R10";
            default: return "R2";
        endcase
    endfunction

    function automatic void ref_xlate(input logic [31:0] va, input logic wr, input logic usr,
                                      input logic [1:0] sz, output logic [31:0] pa, output logic [2:0] err);
        int nm, sel, sh;
        logic bad;
        logic [31:0] base, om;
        pa = 0; err = 0; nm = 0; sel = 0;
        bad = (sz == 2'd1) ? va[0] : (sz >= 2'd2) ? (va[1:0] != 2'b00) : 1'b0;
        if (bad) begin err = 3'd5; return; end
        if (wr && va[31:26] == 6'h38) begin pa = va; return; end
        if (usr && va[31]) begin err = 3'd5; return; end
        if (va[31:26] == 6'h1F) begin pa = va; return; end
        if (!usr && (va[31:29] == 3'd4 || va[31:29] == 3'd5 || va[31:29] == 3'd7)) begin
            pa = va; return;
        end
        for (int i = 0; i < NE; i++) begin
            sh = (m_ent[i].size == 0) ? 0 : (m_ent[i].size == 1) ? 2 : (m_ent[i].size == 2) ? 6 : 10;
            if (m_ent[i].valid && ((va[31:10] >> sh) == (m_ent[i].vpn >> sh)) &&
                (m_ent[i].shared || (single_space && !usr) || m_ent[i].asid == cur_asid)) begin
                nm++; sel = i;
            end
        end
        if (nm > 1) begin err = 3'd2; return; end
        if (nm == 0) begin err = 3'd1; return; end
        if (usr && !m_ent[sel].prot[1]) begin err = 3'd3; return; end
        if (wr && !m_ent[sel].prot[0]) begin err = 3'd3; return; end
        if (wr && !m_ent[sel].dirty) begin err = 3'd4; return; end
        sh = (m_ent[sel].size == 0) ? 0 : (m_ent[sel].size == 1) ? 2 : (m_ent[sel].size == 2) ? 6 : 10;
        base = {3'b000, m_ent[sel].ppn, 10'b0};
        om = (32'd1 << (10 + sh)) - 32'd1;
        pa = (base & ~om) | (va & om);
        if (pa[28:26] == 3'b111) pa[31:28] = 4'hF;
    endfunction

    function automatic void step_urc();
        exp_urc = (exp_urc + 1) % 64;
        if (exp_urc == int'(repl_bound)) exp_urc = 0;
    endfunction

    task automatic drive_load(input int idx, input tlb_ent_t e);
        ld_en = 1'b1; ld_idx = 6'(idx); ld_vpn = e.vpn; ld_asid = e.asid; ld_ppn = e.ppn;
        ld_valid = e.valid; ld_size = e.size; ld_prot = e.prot; ld_dirty = e.dirty; ld_shared = e.shared;
    endtask

    task automatic load(input int idx, input tlb_ent_t e);
        @(negedge clk);
        drive_load(idx, e);
        @(negedge clk);
        ld_en = 1'b0;
        m_ent[idx] = e;
    endtask

    // lookup; when with_ld is set an entry load is driven in the same cycle
    task automatic look_x(input logic [31:0] va, input logic wr, input logic usr, input logic [1:0] sz,
                          input string tag, input bit with_ld, input int li, input tlb_ent_t le);
        logic [31:0] epa;
        logic [2:0]  eer;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr; req_size = sz;
        if (with_ld) drive_load(li, le);
        ref_xlate(va, wr, usr, sz, epa, eer);
        step_urc();
        @(negedge clk);
        req_valid = 1'b0;
        ld_en = 1'b0;
        if (with_ld) m_ent[li] = le;
        check(rsp_valid && rsp_err == eer && rsp_pa == epa,
              (tag == "") ? tag_of(eer) : tag, {rsp_err, rsp_pa[28:0]}, {eer, epa[28:0]});
        if (rsp_pa != epa) $display("  pa actual=%h expected=%h", rsp_pa, epa);
        check(repl_idx == 6'(exp_urc), "R12", 32'(repl_idx), 32'(exp_urc));
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic usr, input logic [1:0] sz,
                        input string tag);
        look_x(va, wr, usr, sz, tag, 1'b0, 0, '0);
    endtask

    function automatic tlb_ent_t mk(input logic [21:0] vpn, input logic [7:0] asid, input logic [18:0] ppn,
                                    input logic [1:0] sz, input logic [1:0] pr, input logic d, input logic sh);
        tlb_ent_t e;
        e.valid = 1'b1; e.vpn = vpn; e.asid = asid; e.ppn = ppn;
        e.size = sz; e.prot = pr; e.dirty = d; e.shared = sh;
        return e;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        tlb_ent_t e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NE; i++) m_ent[i] = '0;
        rst = 1'b1; req_valid = 0; req_va = 0; req_write = 0; req_user = 0; req_size = 0;
        cur_asid = 0; single_space = 0; repl_bound = 0; ld_en = 0; ld_idx = 0; ld_vpn = 0;
        ld_asid = 0; ld_ppn = 0; ld_valid = 0; ld_size = 0; ld_prot = 0; ld_dirty = 0; ld_shared = 0;
        exp_urc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 0);
        check(repl_idx == 6'd0, "R12", 32'(repl_idx), 0);
        look(32'h0200_0044, 0, 0, 2'd2, "R13");

        // fixed windows
        look(32'h8000_0000, 0, 0, 2'd2, "R5");
        look(32'hA000_1234, 0, 0, 2'd0, "R5");
        look(32'hFF00_00CC, 0, 0, 2'd2, "R5");
        look(32'hC000_0000, 0, 0, 2'd2, "R5");
        look(32'h7D00_0088, 0, 1, 2'd2, "R4");
        look(32'h7C00_0010, 1, 0, 2'd1, "R4");
        look(32'hE200_0004, 1, 1, 2'd2, "R3");
        look(32'hA400_0004, 0, 1, 2'd2, "R3");
        look(32'hE400_0000, 1, 1, 2'd2, "R3");
        look(32'hE200_0004, 0, 1, 2'd2, "R3");

        // alignment
        look(32'h8000_0001, 0, 0, 2'd1, "R2");
        look(32'h8000_0001, 0, 0, 2'd0, "R2");
        look(32'h8000_0002, 0, 0, 2'd2, "R2");
        look(32'h8000_0004, 0, 0, 2'd3, "R2");
        look(32'h7D00_0006, 0, 0, 2'd3, "R2");

        // translation
        load(0, mk(22'h0_8000, 8'd0, 19'h3_0000, 2'd1, 2'd3, 1'b1, 1'b0));
        look(32'h0200_0044, 0, 0, 2'd2, "R8");
        look(32'h0200_0FFC, 1, 1, 2'd2, "R8");
        look(32'h0200_1000, 0, 0, 2'd2, "R8");
        cur_asid = 8'd14;
        look(32'h0200_0222, 0, 0, 2'd1, "R6");
        single_space = 1'b1;
        look(32'h0200_0222, 0, 0, 2'd1, "R6");
        look(32'h0200_0222, 0, 1, 2'd1, "R6");
        single_space = 1'b0;
        load(0, mk(22'h0_8000, 8'd13, 19'h3_0000, 2'd1, 2'd3, 1'b1, 1'b1));
        look(32'h0200_0222, 0, 1, 2'd1, "R6");
        cur_asid = 8'd0;
        load(0, mk(22'h0_8000, 8'd0, 19'h3_0000, 2'd3, 2'd3, 1'b1, 1'b0));
        look(32'h020A_BCDE, 0, 0, 2'd1, "R8");
        load(0, mk(22'h0_8000, 8'd0, 19'h3_0000, 2'd2, 2'd3, 1'b1, 1'b0));
        look(32'h0200_F124, 0, 0, 2'd2, "R8");
        look(32'h0201_0000, 0, 0, 2'd2, "R8");
        load(0, mk(22'h0_8000, 8'd0, 19'h3_0000, 2'd0, 2'd3, 1'b1, 1'b0));
        look(32'h0200_03FF, 0, 0, 2'd0, "R8");
        look(32'h0200_0400, 0, 0, 2'd0, "R8");
        load(0, mk(22'h0_8000, 8'd0, 19'h7_0000, 2'd1, 2'd3, 1'b1, 1'b0));
        look(32'h0200_0222, 0, 0, 2'd1, "R11");

        // protection
        load(0, mk(22'h1_0000, 8'd0, 19'h2_8000, 2'd1, 2'd0, 1'b1, 1'b0));
        look(32'h0400_0040, 0, 1, 2'd2, "R9");
        look(32'h0400_0040, 0, 0, 2'd2, "R9");
        look(32'h0400_0040, 1, 0, 2'd2, "R10");
        load(0, mk(22'h1_0000, 8'd0, 19'h2_8000, 2'd1, 2'd2, 1'b1, 1'b0));
        look(32'h0400_0040, 0, 1, 2'd2, "R9");
        look(32'h0400_0040, 1, 1, 2'd2, "R10");
        load(0, mk(22'h1_0000, 8'd0, 19'h2_8000, 2'd1, 2'd3, 1'b0, 1'b0));
        look(32'h0400_0224, 1, 0, 2'd2, "R10");
        look(32'h0400_0224, 0, 1, 2'd2, "R10");

        // multiple match, ahead of protection
        load(1, mk(22'h1_0000, 8'd0, 19'h3_0000, 2'd3, 2'd0, 1'b1, 1'b0));
        look(32'h0400_0040, 0, 1, 2'd2, "R7");
        look(32'h0400_0042, 1, 0, 2'd1, "R7");
        e = m_ent[1]; e.valid = 1'b0;
        load(1, e);
        look(32'h0400_0040, 0, 0, 2'd2, "R7");

        // load and lookup in the same cycle
        look_x(32'h0240_0010, 0, 0, 2'd2, "R13", 1'b1, 2, mk(22'h0_9000, 8'd0, 19'h0_1000, 2'd1, 2'd3, 1'b1, 1'b0));
        look(32'h0240_0010, 0, 0, 2'd2, "R13");

        // replacement pointer wrap
        repl_bound = 6'(exp_urc + 2);
        look(32'h8000_0000, 0, 0, 2'd0, "R12");
        look(32'h8000_0000, 0, 0, 2'd0, "R12");
        check(repl_idx == 6'd0, "R12", 32'(repl_idx), 0);
        repl_bound = 6'd0;

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int k;
            logic [31:0] va;
            if ($urandom_range(0, 3) == 0) begin
                k = $urandom_range(0, 3);
                e = mk({12'(12'h008 + k), 10'($urandom_range(0, 7))}, 8'($urandom_range(0, 3)),
                       19'($urandom), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
                e.valid = ($urandom_range(0, 9) < 7);
                load($urandom_range(0, 11), e);
            end
            cur_asid = 8'($urandom_range(0, 3));
            single_space = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 15) == 0) repl_bound = 6'($urandom);
            k = $urandom_range(0, 3);
            if ($urandom_range(0, 3) == 0) va = $urandom;
            else va = {12'(12'h008 + k), 10'($urandom_range(0, 7)), 10'($urandom)};
            look(va, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "");
        end

        report();
        $finish;
    end

endmodule